// File: doc/BRIEF.md
# Pedestrian Crossing Light Controller

This block sequences the car lamps of a one-way road that has a pedestrian crossing. While no one is waiting the road shows green indefinitely. A press of the crossing button starts a cycle of yellow and then red. If traffic is heavy when the button is pressed, the controller first holds green for a bounded time, and it cuts that hold short as soon as traffic thins out.

The controller is a Moore machine with four phases. The lamps and the phase output depend only on the registered phase. All three timed phases share one up-counter with a synchronous clear. The counter is not cleared between yellow and red, so red ends at the same count that closes the heavy-traffic hold. The reset is synchronous and active high. It returns the phase to idle green and clears the counter on the same edge.

Top module: `xwalk_light_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next phase is idle green (`phase_o` = 0) and the counter is cleared. This holds from any phase, and a yellow period started after such a reset lasts exactly 10 cycles.
- R2: In idle green (0) with `ped_req` low, the phase stays 0 whatever `heavy_traffic` does.
- R3: In idle green (0), `ped_req` high with `heavy_traffic` low moves the phase to yellow (`phase_o` = 2) at the next edge.
- R4: In idle green (0), `ped_req` high with `heavy_traffic` high moves the phase to waiting green (`phase_o` = 1) at the next edge.
- R5: In waiting green (1), `heavy_traffic` low at any edge moves the phase to yellow (2) at that edge.
- R6: In waiting green (1) with `heavy_traffic` held high, the phase lasts exactly 100 cycles and then becomes yellow (2).
- R7: Yellow (2) lasts exactly 10 cycles and then becomes red (`phase_o` = 3).
- R8: Red (3) lasts exactly 90 cycles and then becomes idle green (0).
- R9: `ped_req` has no effect in phases 1, 2 and 3. The dwell lengths of R6, R7 and R8 are unchanged when it is held high.
- R10: Phases 0 and 1 light only `lamp_green`, phase 2 lights only `lamp_yellow`, and phase 3 lights only `lamp_red`. Exactly one lamp is on at all times.
- R11: A single counter times phases 1 to 3. It advances by one per cycle in those phases, it holds in phase 0, and it clears when it reaches 99 or when waiting green sees light traffic. As a result, yellow still lasts 10 cycles after an early exit from waiting green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous main reset, active high |
| ped_req | input | 1 | Pedestrian crossing request button |
| heavy_traffic | input | 1 | Traffic sensor: 1 = heavy, 0 = light |
| lamp_red | output | 1 | Car red lamp |
| lamp_yellow | output | 1 | Car yellow lamp |
| lamp_green | output | 1 | Car green lamp |
| phase_o | output | 2 | Current phase: 0 idle green, 1 waiting green, 2 yellow, 3 red |

## Verification
Every input is sampled at a clock edge, and its effect on `phase_o` appears after that same edge, one register deep. The lamps follow the phase combinationally and change in the same cycle as the phase. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next rising edge. It therefore reads each transition exactly one edge after the stimulus that caused it. Dwell lengths are measured by counting the post-edge samples in which the phase is unchanged, starting at the sample where the phase is first entered. The counts are then compared with 100, 10 and 90.

// File: rtl/xwalk_pkg.sv
package xwalk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_AMBER = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  // Phases in which the shared counter runs.
  function automatic logic phase_timed(input phase_t ph);
    return ph != PH_IDLE;
  endfunction

  // Lamp vector {red, yellow, green}.
  function automatic logic [2:0] phase_lamps(input phase_t ph);
    logic [2:0] l;
    case (ph)
      PH_AMBER: l = 3'b010;
      PH_STOP:  l = 3'b100;
      default:  l = 3'b001;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/xwalk_dwell_counter.sv
module xwalk_dwell_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (clr)     count <= '0;
    else if (en) count <= count + W'(1);
  end
endmodule

// File: rtl/xwalk_phase_fsm.sv
module xwalk_phase_fsm
  import xwalk_pkg::*;
#(
  parameter int W         = 7,
  parameter int AMBER_END = 9,
  parameter int WRAP_END  = 99
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ped_req,
  input  logic         heavy_traffic,
  input  logic [W-1:0] count,
  output phase_t       phase,
  output logic         cnt_clr,
  output logic         cnt_en,
  output logic         amber_done,
  output logic         wrap_hit,
  output logic         wait_abort
);
  phase_t phase_nx;

  assign amber_done = (count == W'(AMBER_END));
  assign wrap_hit   = (count == W'(WRAP_END));
  assign wait_abort = (phase == PH_WAIT) && !heavy_traffic;
  assign cnt_en     = phase_timed(phase);
  assign cnt_clr    = rst || wrap_hit || wait_abort;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:  if (ped_req) phase_nx = heavy_traffic ? PH_WAIT : PH_AMBER;
      PH_WAIT:  if (wait_abort || wrap_hit) phase_nx = PH_AMBER;
      PH_AMBER: if (amber_done) phase_nx = PH_STOP;
      PH_STOP:  if (wrap_hit) phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end
endmodule

// File: rtl/xwalk_lamp_decode.sv
module xwalk_lamp_decode
  import xwalk_pkg::*;
(
  input  phase_t phase,
  output logic   lamp_red,
  output logic   lamp_yellow,
  output logic   lamp_green
);
  logic [2:0] lv;
  assign lv = phase_lamps(phase);
  assign {lamp_red, lamp_yellow, lamp_green} = lv;
endmodule

// File: rtl/xwalk_light_ctrl.sv
module xwalk_light_ctrl
  import xwalk_pkg::*;
#(
  parameter int AMBER_CYC = 10,
  parameter int HOLD_CYC  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ped_req,
  input  logic       heavy_traffic,
  output logic       lamp_red,
  output logic       lamp_yellow,
  output logic       lamp_green,
  output logic [1:0] phase_o
);
  localparam int CNT_W     = $clog2(HOLD_CYC);
  localparam int AMBER_END = AMBER_CYC - 1;
  localparam int WRAP_END  = HOLD_CYC - 1;

  phase_t             phase;
  logic [CNT_W-1:0]   count;
  logic               cnt_clr;
  logic               cnt_en;
  logic               amber_done;
  logic               wrap_hit;
  logic               wait_abort;

  xwalk_phase_fsm #(
    .W(CNT_W), .AMBER_END(AMBER_END), .WRAP_END(WRAP_END)
  ) u_fsm (
    .clk(clk), .rst(rst), .ped_req(ped_req), .heavy_traffic(heavy_traffic),
    .count(count), .phase(phase), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .amber_done(amber_done), .wrap_hit(wrap_hit), .wait_abort(wait_abort)
  );

  xwalk_dwell_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .clr(cnt_clr), .en(cnt_en), .count(count)
  );

  xwalk_lamp_decode u_lamp (
    .phase(phase), .lamp_red(lamp_red), .lamp_yellow(lamp_yellow),
    .lamp_green(lamp_green)
  );

  assign phase_o = phase;
endmodule

// File: rtl/xwalk_light_sva.sv
module xwalk_light_sva #(
  parameter int CNT_W     = 7,
  parameter int AMBER_END = 9,
  parameter int WRAP_END  = 99
) (
  input logic             clk,
  input logic             rst,
  input logic             ped_req,
  input logic             heavy_traffic,
  input logic [1:0]       phase_o,
  input logic             lamp_red,
  input logic             lamp_yellow,
  input logic             lamp_green,
  input logic [CNT_W-1:0] count,
  input logic             cnt_clr,
  input logic             cnt_en
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (phase_o == 2'd0 && count == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd0 && !ped_req) |=> phase_o == 2'd0);

  assert_idle_to_amber_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd0 && ped_req && !heavy_traffic) |=> phase_o == 2'd2);

  assert_idle_to_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd0 && ped_req && heavy_traffic) |=> phase_o == 2'd1);

  assert_wait_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd1 && !heavy_traffic) |=> (phase_o == 2'd2 && count == '0));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd1 && heavy_traffic && count != CNT_W'(WRAP_END)) |=> phase_o == 2'd1);

  assert_amber_end_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd2 && count == CNT_W'(AMBER_END)) |=> phase_o == 2'd3);

  assert_stop_end_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3 && count == CNT_W'(WRAP_END)) |=> phase_o == 2'd0);

  assert_stop_no_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3 && count != CNT_W'(WRAP_END)) |=> phase_o == 2'd3);

  assert_one_lamp_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({lamp_red, lamp_yellow, lamp_green}) == 1);

  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !cnt_clr) |=> count == $past(count) + CNT_W'(1));

  assert_count_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd0 && !cnt_clr) |=> $stable(count));
endmodule

bind xwalk_light_ctrl xwalk_light_sva #(
  .CNT_W(CNT_W), .AMBER_END(AMBER_END), .WRAP_END(WRAP_END)
) u_sva (
  .clk(clk), .rst(rst), .ped_req(ped_req), .heavy_traffic(heavy_traffic),
  .phase_o(phase_o), .lamp_red(lamp_red), .lamp_yellow(lamp_yellow),
  .lamp_green(lamp_green), .count(count), .cnt_clr(cnt_clr), .cnt_en(cnt_en)
);

// File: tb/tb_xwalk_light_ctrl.sv
`timescale 1ns/1ps
module tb_xwalk_light_ctrl;
  logic clk = 1'b0;
  logic rst, ped_req, heavy_traffic;
  logic lamp_red, lamp_yellow, lamp_green;
  logic [1:0] phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  xwalk_light_ctrl dut (
    .clk(clk), .rst(rst), .ped_req(ped_req), .heavy_traffic(heavy_traffic),
    .lamp_red(lamp_red), .lamp_yellow(lamp_yellow), .lamp_green(lamp_green),
    .phase_o(phase_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected lamps {red,yellow,green} restated from R10.
  task automatic check_lamps(input int ph);
    int exp;
    exp = (ph == 3) ? 4 : (ph == 2) ? 2 : 1;
    check({lamp_red, lamp_yellow, lamp_green} == 3'(exp), "R10 lamps",
          int'({lamp_red, lamp_yellow, lamp_green}), exp);
  endtask

  task automatic check_phase(input int exp, input string req);
    check(int'(phase_o) == exp, req, int'(phase_o), exp);
    check_lamps(exp);
  endtask

  // Counts samples spent in phase ph, starting at the current sample.
  task automatic dwell(input int ph, output int n);
    n = 0;
    while (int'(phase_o) == ph && n < 1000) begin
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1; ped_req = 1'b0; heavy_traffic = 1'b0;
    repeat (3) step();
    check_phase(0, "R1 reset phase");
    rst = 1'b0;
    step();
    check_phase(0, "R1 after release");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 20; i++) begin
      heavy_traffic = i[1];
      step();
    end
    check_phase(0, "R2 idle hold");
  endtask

  task automatic t_light_request();
    int n;
    ped_req = 1'b1; heavy_traffic = 1'b0;
    step();
    check_phase(2, "R3 idle to yellow");
    ped_req = 1'b0;
    dwell(2, n);
    check(n == 10, "R7 yellow dwell", n, 10);
    check_phase(3, "R7 yellow to red");
    dwell(3, n);
    check(n == 90, "R8 red dwell", n, 90);
    check_phase(0, "R8 red to idle");
  endtask

  task automatic t_heavy_request();
    int n;
    ped_req = 1'b1; heavy_traffic = 1'b1;
    step();
    check_phase(1, "R4 idle to waiting");
    ped_req = 1'b0;
    dwell(1, n);
    check(n == 100, "R6 waiting dwell", n, 100);
    check_phase(2, "R6 waiting to yellow");
    dwell(2, n);
    check(n == 10, "R7 yellow after full hold", n, 10);
    dwell(3, n);
    check(n == 90, "R8 red after full hold", n, 90);
    heavy_traffic = 1'b0;
  endtask

  task automatic t_early_exit();
    int n;
    ped_req = 1'b1; heavy_traffic = 1'b1;
    step();
    ped_req = 1'b0;
    repeat (36) step();
    check_phase(1, "R6 still waiting");
    heavy_traffic = 1'b0;
    step();
    check_phase(2, "R5 abort to yellow");
    dwell(2, n);
    check(n == 10, "R11 yellow after abort", n, 10);
    dwell(3, n);
    check(n == 90, "R11 red after abort", n, 90);
    check_phase(0, "R8 back to idle");
  endtask

  task automatic t_request_ignored();
    int n;
    ped_req = 1'b1; heavy_traffic = 1'b1;
    step();
    check_phase(1, "R4 enter waiting");
    dwell(1, n);
    check(n == 100, "R9 waiting dwell with request", n, 100);
    dwell(2, n);
    check(n == 10, "R9 yellow dwell with request", n, 10);
    dwell(3, n);
    check(n == 90, "R9 red dwell with request", n, 90);
    ped_req = 1'b0;
    check_phase(0, "R9 idle reached");
    step();
    check_phase(0, "R2 idle after release");
    heavy_traffic = 1'b0;
  endtask

  task automatic t_mid_reset();
    int n;
    ped_req = 1'b1; heavy_traffic = 1'b0;
    step();
    ped_req = 1'b0;
    repeat (4) step();
    check_phase(2, "R7 mid yellow");
    rst = 1'b1;
    step();
    check_phase(0, "R1 reset from yellow");
    rst = 1'b0;
    ped_req = 1'b1;
    step();
    ped_req = 1'b0;
    dwell(2, n);
    check(n == 10, "R1 yellow after reset", n, 10);
    dwell(3, n);
    check(n == 90, "R1 red after reset", n, 90);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_light_request();
    t_heavy_request();
    t_early_exit();
    t_request_ignored();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule